// File: doc/BRIEF.md
# Eight-Point Streaming FFT/IFFT Engine

This block turns a stream of real signed samples into the spectrum of each group of eight samples. It accepts one sample per clock. When eight samples have been accepted, they form one block. The block is reordered and sent through three registered radix-2 decimation-in-time butterfly stages. All eight complex bins are then presented in parallel, in natural order, with a one-cycle valid strobe. A per-block mode bit selects the forward transform or the inverse transform. The inverse uses the same butterfly network with conjugated twiddles and a final divide by eight.

The input side is valid/ready. A sample transfers on a cycle in which both `in_valid` and `in_ready` are high. The engine never stalls, so `in_ready` is high whenever reset is not asserted. A source may insert idle cycles between samples, and the block simply waits for the next accepted sample. The output side has no back-pressure. The consumer must take the bins in the cycle `out_valid` is high. The bins stay on the output until the next block replaces them.

Arithmetic is fixed point. The 8-bit samples grow by one bit per stage, so each output part is 11 bits signed. The constant for √2/2 is 181/256.

Top module: `fft8_dit`

## Requirements
- R1: `in_ready` is low while `rst` is high and high otherwise. A sample is accepted only on a rising edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low are skipped, and the eight accepted samples x0..x7 form a block in arrival order.
- R2: In forward mode, bin k is the radix-2 DIT transform of the block. Stage inputs are in bit-reversed order (0,4,2,6,1,5,3,7). Stage s pairs elements that are 2^s apart and applies twiddle W8^m with m = (position within group)·4/2^s. Each butterfly yields a+Wb and a−Wb. Bin k sits at bits [11k+10 : 11k] of `out_re` (real part) and `out_im` (imaginary part), two's complement.
- R3: W8^0 is a pass-through. W8^2 multiplies by −j in forward mode. W8^1 is (181−181j)/256 and W8^3 is (−181−181j)/256. Each part of an odd twiddle product equals floor((181·S+128)/256), where S is that part's integer sum of ±re and ±im of b.
- R4: With `in_mode` = 1 (inverse), every twiddle is replaced by its conjugate. Every output part is the stage-three result shifted right arithmetically by 3.
- R5: The mode of a block is the value of `in_mode` on the edge that accepts its eighth sample. Values on earlier samples have no effect.
- R6: `out_valid` is high for exactly one cycle, four rising edges after the edge that accepts the eighth sample. The output bins keep their values after that cycle until the next block is presented.
- R7: Reset clears all valid flags and the sample count. A partly gathered block is discarded, so no output appears for it.
- R8: Because the input is real, the imaginary parts of bins 0 and 4 are zero for every block, in both modes.
- R9: Blocks sent back to back with no idle cycle are each transformed correctly, one result every eight clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on `in_data` |
| in_ready | output | 1 | Engine can take a sample (high out of reset) |
| in_data | input | IN_W (8) | Signed input sample |
| in_mode | input | 1 | 0 = forward, 1 = inverse; sampled with the eighth sample |
| out_valid | output | 1 | One-cycle strobe: bins are valid |
| out_re | output | 8·(IN_W+3) (88) | Real parts of bins 0..7, bin k in slice k |
| out_im | output | 8·(IN_W+3) (88) | Imaginary parts of bins 0..7, bin k in slice k |

## Verification
The bench uses impulses at positions 0 and 1 and a constant block. It also sends a block whose alternating sign lands all energy in bin 4, and a full-scale negative block that reaches −1024. A wrong reorder, swapped twiddle or bad rounding would move or mis-size these bins. Mode is flipped on the eighth sample only, which catches an engine that samples mode on the first sample. A reset in the middle of a block must yield no output, and a design that kept the old count would emit a spurious or misaligned block. Idle gaps between samples and back-to-back blocks expose miscounting, and a latency check against the accepting edge catches a missing or extra pipeline register.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int N_PTS   = 8;
  localparam int LOG_N   = 3;
  localparam int HALF    = N_PTS / 2;
  localparam int TW_FRAC = 8;
  localparam int TW_C    = 181;   // round(256 * sqrt(2)/2)

  typedef enum logic {XF_FWD = 1'b0, XF_INV = 1'b1} xform_e;

  function automatic int unsigned bit_rev(input int unsigned idx);
    int unsigned r;
    r = 0;
    for (int b = 0; b < LOG_N; b++)
      r |= ((idx >> b) & 1) << (LOG_N - 1 - b);
    return r;
  endfunction
endpackage

// File: rtl/fft8_s2p.sv
module fft8_s2p
  import fft8_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  input  logic                   in_mode,
  output logic                   in_ready,
  output logic                   blk_valid,
  output xform_e                 blk_mode,
  output logic signed [IN_W-1:0] blk_re [N_PTS]
);
  localparam logic [LOG_N-1:0] LAST = LOG_N'(N_PTS - 1);

  logic [LOG_N-1:0]       cnt;
  logic signed [IN_W-1:0] hold [N_PTS];
  logic                   acc;

  assign in_ready = ~rst;
  assign acc      = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      blk_valid <= 1'b0;
    end else begin
      blk_valid <= acc && (cnt == LAST);
      if (acc) cnt <= cnt + 1'b1;
    end
  end

  // Gather samples; on the eighth, load the block in bit-reversed order.
  always_ff @(posedge clk) begin
    if (acc) begin
      hold[cnt] <= in_data;
      if (cnt == LAST) begin
        blk_mode <= xform_e'(in_mode);
        for (int p = 0; p < N_PTS; p++)
          blk_re[p] <= (bit_rev(p) == N_PTS - 1) ? in_data : hold[bit_rev(p)];
      end
    end
  end

  assert_blk_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> $past(in_valid && in_ready));

  assert_mode_from_last_R5: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> (blk_mode == xform_e'($past(in_mode))));
endmodule

// File: rtl/fft8_stage.sv
module fft8_stage
  import fft8_pkg::*;
#(
  parameter int STG = 0,
  parameter int IW  = 8,
  parameter int OW  = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_i,
  input  xform_e               inv_i,
  input  logic signed [IW-1:0] re_i [N_PTS],
  input  logic signed [IW-1:0] im_i [N_PTS],
  output logic                 v_o,
  output xform_e               inv_o,
  output logic signed [OW-1:0] re_o [N_PTS],
  output logic signed [OW-1:0] im_o [N_PTS]
);
  localparam int SPAN = 1 << STG;
  localparam int PW   = OW + 9;
  localparam logic signed [PW-1:0] TWC = PW'(TW_C);
  localparam logic signed [PW-1:0] RND = PW'(1 << (TW_FRAC - 1));

  logic signed [OW-1:0] nxt_re [N_PTS];
  logic signed [OW-1:0] nxt_im [N_PTS];

  for (genvar p = 0; p < HALF; p++) begin : g_bfly
    localparam int TOP = (p / SPAN) * 2 * SPAN + (p % SPAN);
    localparam int BOT = TOP + SPAN;
    localparam int K   = (p % SPAN) * (HALF / SPAN);

    logic signed [OW-1:0] ar, ai, br, bi, tr, ti;
    assign ar = {{(OW-IW){re_i[TOP][IW-1]}}, re_i[TOP]};
    assign ai = {{(OW-IW){im_i[TOP][IW-1]}}, im_i[TOP]};
    assign br = {{(OW-IW){re_i[BOT][IW-1]}}, re_i[BOT]};
    assign bi = {{(OW-IW){im_i[BOT][IW-1]}}, im_i[BOT]};

    if (K == 0) begin : g_w0
      assign tr = br;
      assign ti = bi;
    end else if (K == 2) begin : g_w2
      // forward: times -j ; inverse: times +j
      assign tr = (inv_i == XF_INV) ? -bi : bi;
      assign ti = (inv_i == XF_INV) ? br : -br;
    end else begin : g_wodd
      localparam bit NEG = (K == 3);
      logic signed [OW-1:0] brs, bis, sr, si;
      logic signed [PW-1:0] pr, pi;
      always_comb begin
        brs = NEG ? -br : br;
        bis = NEG ? -bi : bi;
        sr  = (inv_i == XF_INV) ? (brs - bi) : (brs + bi);
        si  = (inv_i == XF_INV) ? (bis + br) : (bis - br);
        pr  = {{(PW-OW){sr[OW-1]}}, sr} * TWC + RND;
        pi  = {{(PW-OW){si[OW-1]}}, si} * TWC + RND;
      end
      assign tr = OW'(pr >>> TW_FRAC);
      assign ti = OW'(pi >>> TW_FRAC);
    end

    assign nxt_re[TOP] = ar + tr;
    assign nxt_im[TOP] = ai + ti;
    assign nxt_re[BOT] = ar - tr;
    assign nxt_im[BOT] = ai - ti;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    inv_o <= inv_i;
    re_o  <= nxt_re;
    im_o  <= nxt_im;
  end
endmodule

// File: rtl/fft8_dit.sv
module fft8_dit
  import fft8_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [IN_W-1:0]             in_data,
  input  logic                        in_mode,
  output logic                        out_valid,
  output logic [N_PTS*(IN_W+LOG_N)-1:0] out_re,
  output logic [N_PTS*(IN_W+LOG_N)-1:0] out_im
);
  localparam int W1    = IN_W + 1;
  localparam int W2    = IN_W + 2;
  localparam int OUT_W = IN_W + LOG_N;

  logic                   v0, v1, v2, v3;
  xform_e                 m0, m1, m2, m3;
  logic signed [IN_W-1:0] s0_re [N_PTS];
  logic signed [IN_W-1:0] s0_im [N_PTS];
  logic signed [W1-1:0]   s1_re [N_PTS];
  logic signed [W1-1:0]   s1_im [N_PTS];
  logic signed [W2-1:0]   s2_re [N_PTS];
  logic signed [W2-1:0]   s2_im [N_PTS];
  logic signed [OUT_W-1:0] s3_re [N_PTS];
  logic signed [OUT_W-1:0] s3_im [N_PTS];

  always_comb
    for (int p = 0; p < N_PTS; p++) s0_im[p] = '0;

  fft8_s2p #(.IN_W(IN_W)) u_s2p (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .in_ready(in_ready), .blk_valid(v0),
    .blk_mode(m0), .blk_re(s0_re));

  fft8_stage #(.STG(0), .IW(IN_W)) u_stg0 (
    .clk(clk), .rst(rst), .v_i(v0), .inv_i(m0), .re_i(s0_re), .im_i(s0_im),
    .v_o(v1), .inv_o(m1), .re_o(s1_re), .im_o(s1_im));

  fft8_stage #(.STG(1), .IW(W1)) u_stg1 (
    .clk(clk), .rst(rst), .v_i(v1), .inv_i(m1), .re_i(s1_re), .im_i(s1_im),
    .v_o(v2), .inv_o(m2), .re_o(s2_re), .im_o(s2_im));

  fft8_stage #(.STG(2), .IW(W2)) u_stg2 (
    .clk(clk), .rst(rst), .v_i(v2), .inv_i(m2), .re_i(s2_re), .im_i(s2_im),
    .v_o(v3), .inv_o(m3), .re_o(s3_re), .im_o(s3_im));

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v3;
  end

  // Output register: inverse mode divides by N with an arithmetic shift.
  always_ff @(posedge clk) begin
    if (v3) begin
      for (int k = 0; k < N_PTS; k++) begin
        out_re[k*OUT_W +: OUT_W] <= (m3 == XF_INV) ? (s3_re[k] >>> LOG_N) : s3_re[k];
        out_im[k*OUT_W +: OUT_W] <= (m3 == XF_INV) ? (s3_im[k] >>> LOG_N) : s3_im[k];
      end
    end
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(v0, 4));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_real_bins_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_im[0 +: OUT_W] == '0 && out_im[4*OUT_W +: OUT_W] == '0));
endmodule

// File: tb/fft8_dit_bench.sv
module fft8_dit_bench;
  localparam int IN_W  = 8;
  localparam int OUT_W = 11;
  localparam int NP    = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 20 ns period

  logic                rst, in_valid, in_ready, in_mode, out_valid;
  logic [IN_W-1:0]     in_data;
  logic [NP*OUT_W-1:0] out_re, out_im;

  fft8_dit #(.IN_W(IN_W)) u_fft8_dit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
    .out_re(out_re), .out_im(out_im));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int    exp_v[$];
  int    exp_due[$];
  string exp_tag[$];

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int brev(input int p);
    return ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1);
  endfunction

  function automatic int rnd181(input int v);
    return (181 * v + 128) >>> 8;
  endfunction

  // Reference transform from the requirements (R2, R3, R4).
  function automatic void model(input int x[8], input bit inv, output int ore[8], output int oim[8]);
    int re[8], im[8], nr[8], ni[8];
    for (int p = 0; p < 8; p++) begin re[p] = x[brev(p)]; im[p] = 0; end
    for (int s = 0; s < 3; s++) begin
      int h;
      h = 1 << s;
      for (int p = 0; p < 4; p++) begin
        int t, b, m, tr, ti, e1, e2;
        t = (p / h) * 2 * h + (p % h);
        b = t + h;
        m = (p % h) * (4 / h);
        if (m == 0) begin tr = re[b]; ti = im[b]; end
        else if (m == 2) begin
          if (inv) begin tr = -im[b]; ti = re[b]; end
          else     begin tr = im[b];  ti = -re[b]; end
        end else begin
          e1 = (m == 1) ? 1 : -1;
          e2 = inv ? 1 : -1;
          tr = rnd181(e1 * re[b] - e2 * im[b]);
          ti = rnd181(e1 * im[b] + e2 * re[b]);
        end
        nr[t] = re[t] + tr; ni[t] = im[t] + ti;
        nr[b] = re[t] - tr; ni[b] = im[t] - ti;
      end
      re = nr; im = ni;
    end
    for (int k = 0; k < 8; k++) begin
      ore[k] = inv ? (re[k] >>> 3) : re[k];
      oim[k] = inv ? (im[k] >>> 3) : im[k];
    end
  endfunction

  // Driver: feeds one block and pushes the expected result.
  task automatic send_block(input int x[8], input bit mode_last, input bit mode_early,
                            input int gap, input string tag);
    int er[8], ei[8];
    model(x, mode_last, er, ei);
    for (int i = 0; i < 8; i++) begin
      if (i > 0)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); in_valid = 1'b0; in_mode = ~mode_last;
        end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(x[i]);
      in_mode  = (i == 7) ? mode_last : mode_early;
    end
    @(posedge clk); #1;
    for (int k = 0; k < 8; k++) begin exp_v.push_back(er[k]); exp_v.push_back(ei[k]); end
    exp_due.push_back(cyc + 4);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  // Monitor / scoreboard
  bit prev_v = 0;
  logic [NP*OUT_W-1:0] sv_re, sv_im;
  always @(negedge clk) begin
    if (prev_v && !out_valid) begin
      check("R6", "held out_re", int'(out_re == sv_re), 1);
      check("R6", "held out_im", int'(out_im == sv_im), 1);
    end
    if (!rst && out_valid) begin
      if (exp_due.size() == 0) begin
        check("R7", "unexpected out_valid", 1, 0);
      end else begin
        int due;
        string tg;
        due = exp_due.pop_front();
        tg  = exp_tag.pop_front();
        check("R6", {tg, " latency cycle"}, cyc, due);
        for (int k = 0; k < NP; k++) begin
          int ar, ai, xr, xi;
          ar = $signed(out_re[k*OUT_W +: OUT_W]);
          ai = $signed(out_im[k*OUT_W +: OUT_W]);
          xr = exp_v.pop_front();
          xi = exp_v.pop_front();
          check(tg, $sformatf("bin %0d re", k), ar, xr);
          check(tg, $sformatf("bin %0d im", k), ai, xi);
        end
        check("R8", "bin 0 im", $signed(out_im[0 +: OUT_W]), 0);
        check("R8", "bin 4 im", $signed(out_im[4*OUT_W +: OUT_W]), 0);
      end
      sv_re = out_re;
      sv_im = out_im;
    end
    prev_v = !rst && out_valid;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check("WATCHDOG", "run finished", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int x[8];
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", int'(in_ready), 0);
    check("R7", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    #1;
    check("R1", "in_ready after reset", int'(in_ready), 1);

    // R2: impulse at x0
    x = '{100, 0, 0, 0, 0, 0, 0, 0};
    send_block(x, 1'b0, 1'b0, 0, "R2");
    idle(6);
    // R3: impulse at x1 exercises every twiddle
    x = '{0, 100, 0, 0, 0, 0, 0, 0};
    send_block(x, 1'b0, 1'b0, 0, "R3");
    idle(6);
    // R1: constant block with idle gaps between samples
    x = '{50, 50, 50, 50, 50, 50, 50, 50};
    send_block(x, 1'b0, 1'b0, 2, "R1");
    idle(6);
    // R2: ramp
    x = '{-70, -50, -30, -10, 10, 30, 50, 70};
    send_block(x, 1'b0, 1'b0, 1, "R2");
    idle(6);
    // R4: inverse of alternating block, energy in bin 4
    x = '{100, -100, 100, -100, 100, -100, 100, -100};
    send_block(x, 1'b1, 1'b1, 0, "R4");
    idle(6);
    // R4: inverse of impulse at x1
    x = '{0, 100, 0, 0, 0, 0, 0, 0};
    send_block(x, 1'b1, 1'b1, 0, "R4");
    idle(6);
    // R2/R4: full-scale negative block
    x = '{-128, -128, -128, -128, -128, -128, -128, -128};
    send_block(x, 1'b0, 1'b0, 0, "R2");
    send_block(x, 1'b1, 1'b1, 0, "R4");
    idle(6);
    // R5: mode differs only on the eighth sample
    x = '{20, -40, 60, 5, -15, 90, -3, 33};
    send_block(x, 1'b0, 1'b1, 0, "R5");
    send_block(x, 1'b1, 1'b0, 0, "R5");
    idle(6);
    // R7: reset in the middle of a block
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(90 - 30 * i); in_mode = 1'b0;
    end
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    x = '{7, 14, -21, 28, -35, 42, -49, 56};
    send_block(x, 1'b0, 1'b0, 0, "R7");
    idle(6);
    // R9: back-to-back random blocks, alternating modes
    for (int b = 0; b < 8; b++) begin
      int y[8];
      for (int i = 0; i < 8; i++) y[i] = int'($urandom_range(200)) - 100;
      send_block(y, b[0], b[0], 0, "R9");
    end
    idle(12);
    check("R9", "scoreboard drained", exp_due.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule